// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the interrupt causes of a multi-channel audio DMA engine and turns them into summary words and one level interrupt. Channel direction is fixed by parity: even channels move data from memory to a device (transmit) and odd channels move data from a device to memory (receive). Every channel owns a cause register with a descriptor-done flag and an error flag. Single-cycle event pulses from the transfer engine set the flags. Software clears them by writing ones. A per-channel enable register with the same layout decides which flags count.

The transmit summary word carries one bit per channel pair for the even channels, and the receive summary word carries one for the odd channels. A global word collects chip-level event pulses. The interrupt output is driven by a two-state machine: `IRQ_IDLE` goes to `IRQ_RAISED` when any summary word is nonzero, and `IRQ_RAISED` goes back to `IRQ_IDLE` when all of them are zero. The block also holds a run bit per channel for each direction. Software sets and clears these bits through go and halt registers, and the transfer engine reads them.

Word addresses: 0x00 transmit summary, 0x01 receive summary, 0x02 global word, 0x04 transmit go, 0x05 transmit halt, 0x06 receive go, 0x07 receive halt. Channel c has its cause register at 0x40+2c and its enable register at 0x41+2c. All other addresses read as zero.

Top module: `dma_irq_aggregator`

## Requirements
- R1: An event pulse on `ev_done[c]` sets bit 0 of channel c's cause register, and an event pulse on `ev_err[c]` sets bit 6 of it, at the clock edge that samples the pulse. All other bits of the cause register read as zero.
- R2: Writing a one to bit 0 or bit 6 of a cause register clears that flag. Writing a zero to a flag leaves it unchanged.
- R3: If an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R4: The enable register keeps only bits 0 (done) and 6 (error), and reads them back at those positions. A cause flag counts toward the summary only when its enable bit is one.
- R5: Bit k of the transmit summary (0x00) is one when channel 2k has an enabled cause set. Bit k of the receive summary (0x01) is one when channel 2k+1 has an enabled cause set.
- R6: Summary bits and run bits that belong to channels that do not exist (for c >= NUM_CH) always read as zero, and writes to them are ignored.
- R7: A pulse on `glb_ev[i]` sets bit i of the global word (0x02). Only a write of all ones (0xFFFFFFFF) clears the word. Any other write leaves it unchanged.
- R8: `irq` goes to one at the clock edge after any summary or global bit becomes one. It goes back to zero at the clock edge after all of them are zero.
- R9: Writing a mask to a go register (0x04 transmit, 0x06 receive) sets the run bits at positions channel/2. Writing a mask to the matching halt register (0x05, 0x07) clears them. Reading either register returns the run bits, which also drive `tx_run` and `rx_run`.
- R10: While `rst_n` is low, all flags, enables, run bits and the global word are zero, and `irq` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_done | input | NUM_CH | Descriptor-done event pulse, one bit per channel |
| ev_err | input | NUM_CH | Error event pulse, one bit per channel |
| glb_ev | input | GLB_W | Global event pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| tx_run | output | 32 | Run bits of the transmit channels, bit k for channel 2k |
| rx_run | output | 32 | Run bits of the receive channels, bit k for channel 2k+1 |
| irq | output | 1 | Level interrupt output |

## Verification
The assertions assume that event inputs are single-cycle pulses driven between clock edges. They assume that `reg_wr` writes one register per cycle, and that reset is applied from time zero. The bench changes every input on the falling clock edge. It pulses events for exactly one cycle, and it combines a clearing write with an event in the same cycle only in the directed test for R3.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int DW     = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] A_TXSUM  = 8'h00;
    localparam logic [ADDR_W-1:0] A_RXSUM  = 8'h01;
    localparam logic [ADDR_W-1:0] A_GLB    = 8'h02;
    localparam logic [ADDR_W-1:0] A_TXGO   = 8'h04;
    localparam logic [ADDR_W-1:0] A_TXHALT = 8'h05;
    localparam logic [ADDR_W-1:0] A_RXGO   = 8'h06;
    localparam logic [ADDR_W-1:0] A_RXHALT = 8'h07;
    localparam int                CH_BASE  = 'h40;

    localparam int DONE_BIT = 0;
    localparam int ERR_BIT  = 6;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_RAISED
    } irq_state_e;
endpackage

// File: rtl/dma_irq_chan.sv
module dma_irq_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_wr,
    input  logic mask_wr,
    input  logic w_done,
    input  logic w_err,
    input  logic ev_done,
    input  logic ev_err,
    output logic done_q,
    output logic err_q,
    output logic men_done_q,
    output logic men_err_q,
    output logic pend
);
    // set wins over clear (R3)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            men_done_q <= 1'b0;
            men_err_q  <= 1'b0;
        end else begin
            done_q <= (done_q & ~(stat_wr & w_done)) | ev_done;
            err_q  <= (err_q  & ~(stat_wr & w_err))  | ev_err;
            if (mask_wr) begin
                men_done_q <= w_done;
                men_err_q  <= w_err;
            end
        end
    end

    assign pend = (done_q & men_done_q) | (err_q & men_err_q);
endmodule

// File: rtl/dma_irq_run.sv
module dma_irq_run #(
    parameter int             W     = 32,
    parameter logic [W-1:0]   VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_wr,
    input  logic         halt_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] run_q
);
    logic [W-1:0] set_m, clr_m;

    always_comb begin
        set_m = go_wr   ? (wdata & VALID) : '0;
        clr_m = halt_wr ? wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= (run_q | set_m) & ~clr_m;
    end
endmodule

// File: rtl/dma_irq_fsm.sv
module dma_irq_fsm
    import dma_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend,
    output logic irq
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (any_pend)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!any_pend) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int GLB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ev_done,
    input  logic [NUM_CH-1:0] ev_err,
    input  logic [GLB_W-1:0]  glb_ev,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic [DW-1:0]     tx_run,
    output logic [DW-1:0]     rx_run,
    output logic              irq
);
    localparam int NTX = (NUM_CH + 1) / 2;
    localparam int NRX = NUM_CH / 2;
    localparam logic [DW-1:0] TX_VALID = DW'((64'd1 << NTX) - 64'd1);
    localparam logic [DW-1:0] RX_VALID = DW'((64'd1 << NRX) - 64'd1);

    logic [NUM_CH-1:0] stat_wr, mask_wr, done_q, err_q, mdone_q, merr_q, pend;
    logic [DW-1:0]     tx_sum, rx_sum;
    logic [GLB_W-1:0]  glb_q;
    logic              glb_clr, any_pend;

    // address decode for per-channel registers
    always_comb begin
        stat_wr = '0;
        mask_wr = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            stat_wr[c] = reg_wr && (reg_addr == ADDR_W'(CH_BASE + 2 * c));
            mask_wr[c] = reg_wr && (reg_addr == ADDR_W'(CH_BASE + 2 * c + 1));
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dma_irq_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .stat_wr    (stat_wr[c]),
            .mask_wr    (mask_wr[c]),
            .w_done     (reg_wdata[DONE_BIT]),
            .w_err      (reg_wdata[ERR_BIT]),
            .ev_done    (ev_done[c]),
            .ev_err     (ev_err[c]),
            .done_q     (done_q[c]),
            .err_q      (err_q[c]),
            .men_done_q (mdone_q[c]),
            .men_err_q  (merr_q[c]),
            .pend       (pend[c])
        );
    end

    // summary words: even channels to transmit, odd to receive
    for (genvar k = 0; k < DW; k++) begin : g_sum
        if (2 * k < NUM_CH) begin : g_tx
            assign tx_sum[k] = pend[2 * k];
        end else begin : g_tx0
            assign tx_sum[k] = 1'b0;
        end
        if (2 * k + 1 < NUM_CH) begin : g_rx
            assign rx_sum[k] = pend[2 * k + 1];
        end else begin : g_rx0
            assign rx_sum[k] = 1'b0;
        end
    end

    // global word: cleared only by an all-ones write, set wins
    assign glb_clr = reg_wr && (reg_addr == A_GLB) && (reg_wdata == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) glb_q <= '0;
        else        glb_q <= (glb_clr ? '0 : glb_q) | glb_ev;
    end

    dma_irq_run #(.W(DW), .VALID(TX_VALID)) u_txrun (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_wr   (reg_wr && reg_addr == A_TXGO),
        .halt_wr (reg_wr && reg_addr == A_TXHALT),
        .wdata   (reg_wdata),
        .run_q   (tx_run)
    );

    dma_irq_run #(.W(DW), .VALID(RX_VALID)) u_rxrun (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_wr   (reg_wr && reg_addr == A_RXGO),
        .halt_wr (reg_wr && reg_addr == A_RXHALT),
        .wdata   (reg_wdata),
        .run_q   (rx_run)
    );

    assign any_pend = (|tx_sum) | (|rx_sum) | (|glb_q);

    dma_irq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_pend (any_pend),
        .irq      (irq)
    );

    // read mux
    always_comb begin
        case (reg_addr)
            A_TXSUM:            reg_rdata = tx_sum;
            A_RXSUM:            reg_rdata = rx_sum;
            A_GLB:              reg_rdata = DW'(glb_q);
            A_TXGO, A_TXHALT:   reg_rdata = tx_run;
            A_RXGO, A_RXHALT:   reg_rdata = rx_run;
            default:            reg_rdata = '0;
        endcase
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr == ADDR_W'(CH_BASE + 2 * c)) begin
                reg_rdata           = '0;
                reg_rdata[DONE_BIT] = done_q[c];
                reg_rdata[ERR_BIT]  = err_q[c];
            end else if (reg_addr == ADDR_W'(CH_BASE + 2 * c + 1)) begin
                reg_rdata           = '0;
                reg_rdata[DONE_BIT] = mdone_q[c];
                reg_rdata[ERR_BIT]  = merr_q[c];
            end
        end
    end
endmodule

// File: rtl/dma_irq_checker.sv
module dma_irq_checker #(
    parameter int NUM_CH = 5,
    parameter int GLB_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ev_done,
    input logic [NUM_CH-1:0] ev_err,
    input logic [NUM_CH-1:0] stat_wr,
    input logic              w_done,
    input logic [NUM_CH-1:0] done_q,
    input logic [NUM_CH-1:0] err_q,
    input logic [31:0]       tx_sum,
    input logic [31:0]       rx_sum,
    input logic [GLB_W-1:0]  glb_q,
    input logic              glb_clr,
    input logic              irq
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R1 and R3: a pulse always leaves the flag set
        a_r3_done_set: assert property (@(posedge clk) disable iff (!rst_n)
            ev_done[c] |=> done_q[c]);
        a_r1_err_set: assert property (@(posedge clk) disable iff (!rst_n)
            ev_err[c] |=> err_q[c]);
        a_r2_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_wr[c] && w_done && !ev_done[c]) |=> !done_q[c]);
    end

    a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ((|tx_sum) || (|rx_sum) || (|glb_q)) |=> irq);
    a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|tx_sum) && !(|rx_sum) && !(|glb_q)) |=> !irq);
    a_r7_glb_keep: assert property (@(posedge clk) disable iff (!rst_n)
        ((|glb_q) && !glb_clr) |=> (|glb_q));
    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!irq && glb_q == '0));
endmodule

bind dma_irq_aggregator dma_irq_checker #(.NUM_CH(NUM_CH), .GLB_W(GLB_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_done (ev_done),
    .ev_err  (ev_err),
    .stat_wr (stat_wr),
    .w_done  (reg_wdata[0]),
    .done_q  (done_q),
    .err_q   (err_q),
    .tx_sum  (tx_sum),
    .rx_sum  (rx_sum),
    .glb_q   (glb_q),
    .glb_clr (glb_clr),
    .irq     (irq)
);

// File: tb/tb_dma_irq_aggregator.sv
`timescale 1ns/1ps
module tb_dma_irq_aggregator;
    localparam int NUM_CH = 5;
    localparam int GLB_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] ev_done = '0, ev_err = '0;
    logic [GLB_W-1:0]  glb_ev = '0;
    logic              reg_wr = 1'b0;
    logic [7:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata, tx_run, rx_run;
    logic              irq;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dma_irq_aggregator #(.NUM_CH(NUM_CH), .GLB_W(GLB_W)) dut (
        .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_err(ev_err),
        .glb_ev(glb_ev), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_run(tx_run),
        .rx_run(rx_run), .irq(irq)
    );

    // entry: {channel[3:0], cause[1:0] (1 done, 2 error), enable[7:0], exp_tx[3:0], exp_rx[3:0]}
    localparam logic [21:0] TBL [8] = '{
        {4'd0, 2'd1, 8'h01, 4'h1, 4'h0},
        {4'd1, 2'd1, 8'h01, 4'h0, 4'h1},
        {4'd2, 2'd2, 8'h40, 4'h2, 4'h0},
        {4'd3, 2'd2, 8'h41, 4'h0, 4'h2},
        {4'd4, 2'd1, 8'h40, 4'h0, 4'h0},
        {4'd4, 2'd2, 8'h40, 4'h4, 4'h0},
        {4'd1, 2'd2, 8'h01, 4'h0, 4'h0},
        {4'd3, 2'd1, 8'h00, 4'h0, 4'h0}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic pulse(input logic [NUM_CH-1:0] d, input logic [NUM_CH-1:0] e);
        @(negedge clk);
        ev_done = d; ev_err = e;
        @(negedge clk);
        ev_done = '0; ev_err = '0;
    endtask

    task automatic clear_all();
        for (int c = 0; c < NUM_CH; c++) begin
            wr(8'(8'h40 + 2 * c), 32'h41);
            wr(8'(8'h41 + 2 * c), 32'h0);
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        @(negedge clk);
        // R10: reset state
        check("R10 irq in reset", {31'b0, irq}, 32'h0);
        rd(8'h00, v); check("R10 tx summary", v, 32'h0);
        rd(8'h02, v); check("R10 global", v, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: R1, R4, R5, R6, R8
        for (int i = 0; i < 8; i++) begin
            logic [3:0] ch;
            logic [NUM_CH-1:0] onehot;
            ch = TBL[i][21:18];
            onehot = NUM_CH'(1) << ch;
            clear_all();
            wr(8'(8'h41 + 2 * ch), 32'(TBL[i][15:8]));
            pulse(TBL[i][17:16] == 2'd1 ? onehot : '0, TBL[i][17:16] == 2'd2 ? onehot : '0);
            rd(8'(8'h40 + 2 * ch), v);
            check("R1 cause flag", v, TBL[i][17:16] == 2'd1 ? 32'h01 : 32'h40);
            rd(8'h00, v); check("R5 tx summary", v, 32'(TBL[i][7:4]));
            rd(8'h01, v); check("R5 rx summary", v, 32'(TBL[i][3:0]));
            @(negedge clk);
            check("R8 irq level", {31'b0, irq}, {31'b0, (TBL[i][7:0] != 8'h0)});
        end

        // R4: enable keeps only bits 0 and 6
        clear_all();
        wr(8'h41, 32'hFFFF_FFFF);
        rd(8'h41, v); check("R4 enable readback", v, 32'h41);

        // R6: all channels, all causes enabled
        for (int c = 0; c < NUM_CH; c++) wr(8'(8'h41 + 2 * c), 32'h41);
        pulse('1, '1);
        rd(8'h00, v); check("R6 tx summary width", v, 32'h7);
        rd(8'h01, v); check("R6 rx summary width", v, 32'h3);
        rd(8'h42, v); check("R1 both flags", v, 32'h41);

        // R2: writing zeros keeps flags, writing one clears
        wr(8'h42, 32'h0);
        rd(8'h42, v); check("R2 zero write kept", v, 32'h41);
        wr(8'h42, 32'h40);
        rd(8'h42, v); check("R2 error cleared", v, 32'h01);

        // R3: clear and set in the same cycle on channel 2
        pulse(5'b00000, 5'b00100);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h44; reg_wdata = 32'h41; ev_done = 5'b00100;
        @(negedge clk);
        reg_wr = 1'b0; ev_done = '0;
        rd(8'h44, v); check("R3 set wins", v, 32'h01);

        // R8 timing: irq follows one edge after the last pending cause goes away
        clear_all();
        @(negedge clk);
        check("R8 irq low", {31'b0, irq}, 32'h0);
        wr(8'h41, 32'h01);
        pulse(5'b00001, '0);
        check("R8 irq not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R8 irq raised", {31'b0, irq}, 32'h1);
        wr(8'h40, 32'h01);
        check("R8 irq still high", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R8 irq dropped", {31'b0, irq}, 32'h0);

        // R7: global word
        @(negedge clk); glb_ev = 4'b1010;
        @(negedge clk); glb_ev = '0;
        rd(8'h02, v); check("R7 global set", v, 32'hA);
        @(negedge clk);
        check("R7 global drives irq", {31'b0, irq}, 32'h1);
        wr(8'h02, 32'h0000_FFFF);
        rd(8'h02, v); check("R7 partial write ignored", v, 32'hA);
        wr(8'h02, 32'hFFFF_FFFF);
        rd(8'h02, v); check("R7 all-ones clears", v, 32'h0);

        // R9 and R6: run bits
        wr(8'h04, 32'h5);
        rd(8'h04, v); check("R9 tx go", v, 32'h5);
        wr(8'h04, 32'hF8);
        rd(8'h05, v); check("R6 tx absent run bits", v, 32'h5);
        wr(8'h05, 32'h1);
        check("R9 tx halt port", tx_run, 32'h4);
        wr(8'h06, 32'h7);
        rd(8'h07, v); check("R9 rx go limited", v, 32'h3);
        wr(8'h07, 32'h2);
        check("R9 rx halt port", rx_run, 32'h1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule